// File: doc/BRIEF.md
# Start-up Reset Sequencer

This block produces the single active-low reset that keeps the processor core idle while a chip powers up, recovers from a supply dip, or resumes from sleep. A power-on pulse starts the sequence. The sequencer first waits out a supply-settling delay, which it counts in ticks of a slow internal RC time base. It then waits out a crystal-settling delay, which it counts in cycles of the main oscillator clock. Only after both delays does the core leave reset.

A brown-out level holds the core in reset for as long as it is asserted, and the settling delay starts again when it clears. The external active-low reset pad passes through a synchronizer and a run-length glitch filter. A configuration bit can disconnect the pad entirely. A one-cycle watchdog request resets the core for one cycle and affects nothing else. A wake event that arrives while running re-enters the crystal-settling wait, but only when the oscillator mode uses a crystal or resonator.

Top module: `startup_reset_seq`

## Requirements
- R1: While `por_i` is high the output `core_rst_n_o` is low on the following clock edge. After power-on the sequence is: supply delay first, then crystal delay when that applies, and only then release.
- R2: The supply delay lasts until the `PWRT_US/RC_TICK_US`-th `rc_tick_i` pulse seen in that phase (72 ticks by default). Main clock cycles without a tick do not advance it.
- R3: `pwrt_off_i` is an active-low enable for the supply delay. A value of 1 skips the delay, so the sequencer leaves that phase on the first clock edge. A value of 0 keeps the delay.
- R4: The crystal delay lasts `OST_CYCLES` main clock cycles (default 1024). It applies only when `osc_mode_i` is 0, 1 or 2, the crystal and resonator modes. Values 3 to 7 skip it.
- R5: The crystal delay runs only after a power-on or after `wake_i` while running. It never follows a brown-out.
- R6: While `bod_i` is high the core stays in reset. When `bod_i` falls, the supply delay restarts from zero.
- R7: The pad reset takes effect only after the pad has been seen low for `FILT_LEN` consecutive synchronized samples (default 4). A shorter low pulse leaves `core_rst_n_o` high.
- R8: When `int_mrst_i` is 1 the pad is treated as tied high, and a low pad has no effect.
- R9: A one-cycle `wdt_i` pulse drives `core_rst_n_o` low for exactly the next cycle. It does not restart any delay.
- R10: `core_rst_n_o` is registered. It rises one edge after the sequencer reaches its running phase, provided no other reset cause is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_i | input | 1 | Power-on reset pulse, synchronous, active high |
| bod_i | input | 1 | Brown-out detect level, active high |
| mrst_pad_n_i | input | 1 | External reset pad, active low, asynchronous |
| wake_i | input | 1 | Wake-from-sleep event, one cycle |
| wdt_i | input | 1 | Watchdog reset request, one cycle |
| rc_tick_i | input | 1 | Slow RC time-base tick, one cycle wide |
| pwrt_off_i | input | 1 | Supply-delay disable (1 = skip) |
| int_mrst_i | input | 1 | 1 = ignore pad, treat as high |
| osc_mode_i | input | 3 | Oscillator mode; 0..2 are crystal/resonator |
| core_rst_n_o | output | 1 | Reset to the core, active low |

## Verification
The hardest states to reach are a wake event in a crystal mode and a brown-out that clears while the mode is still a crystal mode. Both need the sequencer already running, which is about a thousand cycles after power-on. Only the second must skip the crystal delay. The bench first runs the full power-on sequence in a crystal mode. It then issues wake and brown-out from the running state and measures the release latency in each case, and it repeats the wake in a non-crystal mode. Pad pulses one cycle either side of the filter length show whether the filter boundary sits in the right place.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        PH_PWRT = 2'd0,
        PH_OST  = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    localparam logic [2:0] OSC_LAST_XTAL = 3'd2;

    // crystal or resonator modes need the start-up wait
    function automatic logic needs_ost(input logic [2:0] mode);
        return mode <= OSC_LAST_XTAL;
    endfunction

endpackage

// File: rtl/mrst_filter.sv
module mrst_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_n,
    input  logic bypass,
    output logic active
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_run;
    logic          pin_eff;

    assign pin_eff = bypass | pad_n;
    assign active  = (low_run == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            low_run <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_eff};
            if (sync_q[1])
                low_run <= '0;
            else if (low_run != FULL)
                low_run <= low_run + 1'b1;
        end
    end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   bod,
    input  logic   tick,
    input  logic   pwrt_off,
    input  logic   xtal,
    input  logic   wake,
    output phase_e phase
);
    localparam int MAXC = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PT_LAST  = CW'(PWRT_TICKS - 1);
    localparam logic [CW-1:0] OST_LAST = CW'(OST_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          ost_pend;
    logic          pwrt_done;

    assign pwrt_done = pwrt_off || (tick && cnt == PT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_PWRT;
            ost_pend <= 1'b1;
            cnt      <= '0;
        end else if (bod) begin
            phase    <= PH_PWRT;
            ost_pend <= 1'b0;
            cnt      <= '0;
        end else begin
            unique case (phase)
                PH_PWRT: begin
                    if (pwrt_done) begin
                        phase <= (ost_pend && xtal) ? PH_OST : PH_RUN;
                        cnt   <= '0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_OST: begin
                    if (cnt == OST_LAST) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (wake && xtal) begin
                        phase <= PH_OST;
                        cnt   <= '0;
                    end
                end
                default: begin
                    phase <= PH_PWRT;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/startup_reset_seq.sv
module startup_reset_seq
    import rstseq_pkg::*;
#(
    parameter int PWRT_US    = 72000,
    parameter int RC_TICK_US = 1000,
    parameter int OST_CYCLES = 1024,
    parameter int FILT_LEN   = 4
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       bod_i,
    input  logic       mrst_pad_n_i,
    input  logic       wake_i,
    input  logic       wdt_i,
    input  logic       rc_tick_i,
    input  logic       pwrt_off_i,
    input  logic       int_mrst_i,
    input  logic [2:0] osc_mode_i,
    output logic       core_rst_n_o
);
    localparam int PWRT_RAW   = PWRT_US / RC_TICK_US;
    localparam int PWRT_TICKS = (PWRT_RAW < 1) ? 1 : PWRT_RAW;

    phase_e phase;
    logic   mrst_act;

    mrst_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst    (por_i),
        .pad_n  (mrst_pad_n_i),
        .bypass (int_mrst_i),
        .active (mrst_act)
    );

    rstseq_fsm #(.PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES)) u_fsm (
        .clk      (clk),
        .rst      (por_i),
        .bod      (bod_i),
        .tick     (rc_tick_i),
        .pwrt_off (pwrt_off_i),
        .xtal     (needs_ost(osc_mode_i)),
        .wake     (wake_i),
        .phase    (phase)
    );

    always_ff @(posedge clk) begin
        if (por_i)
            core_rst_n_o <= 1'b0;
        else
            core_rst_n_o <= (phase == PH_RUN) && !mrst_act && !wdt_i && !bod_i;
    end
endmodule

// File: rtl/startup_reset_seq_chk.sv
module startup_reset_seq_chk
    import rstseq_pkg::*;
(
    input logic       clk,
    input logic       por_i,
    input logic       bod_i,
    input logic       wdt_i,
    input logic       wake_i,
    input logic [2:0] osc_mode_i,
    input logic [1:0] phase,
    input logic       mrst_act,
    input logic       core_rst_n_o
);
    // R6
    bod_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        bod_i |=> (!core_rst_n_o && phase == PH_PWRT));

    // R9
    wdt_pulse_chk: assert property (@(posedge clk) disable iff (por_i)
        wdt_i |=> !core_rst_n_o);

    // R10
    release_src_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(core_rst_n_o) |-> $past(phase) == PH_RUN);

    // R5
    wake_ost_chk: assert property (@(posedge clk) disable iff (por_i)
        (phase == PH_RUN && wake_i && !bod_i && osc_mode_i <= 3'd2) |=> phase == PH_OST);

    // R7
    mrst_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        mrst_act |=> !core_rst_n_o);

    // R1
    phase_legal_chk: assert property (@(posedge clk) disable iff (por_i)
        phase != 2'd3);
endmodule

bind startup_reset_seq startup_reset_seq_chk u_chk (
    .clk          (clk),
    .por_i        (por_i),
    .bod_i        (bod_i),
    .wdt_i        (wdt_i),
    .wake_i       (wake_i),
    .osc_mode_i   (osc_mode_i),
    .phase        (phase),
    .mrst_act     (mrst_act),
    .core_rst_n_o (core_rst_n_o)
);

// File: tb/startup_reset_seq_test.sv
module startup_reset_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PWRT_US    = 8000;
    localparam int RC_TICK_US = 1000;
    localparam int PT         = PWRT_US / RC_TICK_US;
    localparam int OST        = 1024;
    localparam int FILT       = 4;

    logic clk = 1'b0;
    logic por = 1'b1, bod = 1'b0, pad_n = 1'b1, wake = 1'b0, wdt = 1'b0;
    logic tick = 1'b0, pwrt_off = 1'b0, int_mrst = 1'b0;
    logic [2:0] osc = 3'd1;
    logic core_rst_n;

    int n_checks = 0, n_fail = 0;
    bit checking = 1'b0, done = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    startup_reset_seq #(.PWRT_US(PWRT_US), .RC_TICK_US(RC_TICK_US),
                        .OST_CYCLES(OST), .FILT_LEN(FILT)) uut (
        .clk(clk), .por_i(por), .bod_i(bod), .mrst_pad_n_i(pad_n),
        .wake_i(wake), .wdt_i(wdt), .rc_tick_i(tick), .pwrt_off_i(pwrt_off),
        .int_mrst_i(int_mrst), .osc_mode_i(osc), .core_rst_n_o(core_rst_n));

    // slow time base: one tick every 4 clocks
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick <= (tdiv == 0);
    end

    // behavioural reference: phase 0 = supply wait, 1 = crystal wait, 2 = running
    int m_phase = 0, m_cnt = 0, m_low = 0;
    bit m_pend = 1, m_s1 = 1, m_s2 = 1, m_exp = 0;
    always @(posedge clk) begin
        int nl;
        bit pe, xt;
        pe = int_mrst | pad_n;
        xt = (osc <= 3'd2);
        if (por) begin
            m_s1 = 1; m_s2 = 1; m_low = 0; m_phase = 0; m_pend = 1; m_cnt = 0; m_exp = 0;
        end else begin
            m_exp = (m_phase == 2) && (m_low != FILT) && !wdt && !bod;
            nl = m_s2 ? 0 : ((m_low < FILT) ? m_low + 1 : FILT);
            m_s2 = m_s1; m_s1 = pe; m_low = nl;
            if (bod) begin
                m_phase = 0; m_pend = 0; m_cnt = 0;
            end else if (m_phase == 0) begin
                if (pwrt_off || (tick && m_cnt == PT - 1)) begin
                    m_phase = (m_pend && xt) ? 1 : 2; m_cnt = 0;
                end else if (tick) m_cnt++;
            end else if (m_phase == 1) begin
                if (m_cnt == OST - 1) begin m_phase = 2; m_cnt = 0; end
                else m_cnt++;
            end else if (wake && xt) begin
                m_phase = 1; m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (checking && !done) begin
            n_checks++;
            if (core_rst_n !== m_exp) begin
                n_fail++;
                $display("FAIL %s cycle compare: actual=%b expected=%b at %0t",
                         cur_req, core_rst_n, m_exp, $time);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_por();
        por = 1'b1;
        repeat (2) @(negedge clk);
        por = 1'b0;
    endtask

    task automatic wait_run(input int maxc, output int cyc);
        cyc = 0;
        while (core_rst_n !== 1'b1 && cyc < maxc) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int cyc;
        @(negedge clk);
        checking = 1'b1;
        cur_req = "R1";
        check("R1 reset state", core_rst_n, 0);
        @(negedge clk);

        // power-on in crystal mode: supply wait then crystal wait
        cur_req = "R2";
        por = 1'b0;
        wait_run(3000, cyc);
        cur_req = "R4";
        check("R4 released after both delays", core_rst_n, 1);
        check("R4 crystal delay counted", (cyc >= OST) ? 1 : 0, 1);

        // short pad pulse below filter length
        cur_req = "R7";
        pad_n = 1'b0; repeat (FILT - 1) @(negedge clk); pad_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R7 short pulse ignored", core_rst_n, 1);
        pad_n = 1'b0; repeat (FILT + 4) @(negedge clk);
        check("R7 long pulse resets", core_rst_n, 0);
        pad_n = 1'b1; repeat (6) @(negedge clk);
        check("R7 release after pad high", core_rst_n, 1);

        // pad disconnected
        cur_req = "R8";
        int_mrst = 1'b1; @(negedge clk);
        pad_n = 1'b0; repeat (12) @(negedge clk);
        check("R8 pad ignored", core_rst_n, 1);
        pad_n = 1'b1; repeat (4) @(negedge clk);
        int_mrst = 1'b0; repeat (2) @(negedge clk);

        // watchdog pulse
        cur_req = "R9";
        wdt = 1'b1; @(negedge clk); wdt = 1'b0;
        check("R9 one-cycle reset", core_rst_n, 0);
        @(negedge clk);
        check("R9 no delay restart", core_rst_n, 1);

        // brown-out: supply wait again, no crystal wait
        cur_req = "R6";
        bod = 1'b1; repeat (5) @(negedge clk);
        check("R6 held during brown-out", core_rst_n, 0);
        bod = 1'b0;
        wait_run(3000, cyc);
        cur_req = "R5";
        check("R5 no crystal wait after brown-out", (cyc < 200) ? 1 : 0, 1);
        check("R6 supply wait ran", (cyc >= 4 * (PT - 1)) ? 1 : 0, 1);

        // wake in crystal mode
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        @(negedge clk);
        check("R5 wake enters crystal wait", core_rst_n, 0);
        wait_run(3000, cyc);
        check("R5 wake crystal delay length", (cyc >= OST - 4) ? 1 : 0, 1);

        // wake in non-crystal mode
        cur_req = "R4";
        osc = 3'd4; @(negedge clk);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 wake skipped for RC mode", core_rst_n, 1);

        // power-on with supply wait disabled, RC mode
        cur_req = "R3";
        pwrt_off = 1'b1;
        do_por();
        wait_run(3000, cyc);
        check("R3 fast release", (cyc <= 4) ? 1 : 0, 1);

        // supply wait disabled, crystal mode
        cur_req = "R10";
        osc = 3'd2;
        do_por();
        wait_run(3000, cyc);
        check("R10 crystal wait only", (cyc >= OST && cyc < OST + 8) ? 1 : 0, 1);
        pwrt_off = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule